// File: doc/BRIEF.md
# Transmit Overhead Error-Injection Unit

This block sits in a SONET/SDH-style transmit path, in front of the stage that merges overhead into the outgoing frame. Each incoming byte carries a role tag saying whether it is payload, one of the parity bytes (section parity, one of the three line parity octets, path parity), the far-end block error byte, or some other overhead byte. The block hands every byte on one cycle later, after three kinds of change. It can corrupt a chosen parity byte exactly once, by XOR with an error pattern. It can force the far-end block error bits to all zeros or all ones. It can blank overhead fields that have been disabled.

Software writes a configuration word. The word holds a 3-bit error select, two FEBE force bits and a five-bit disable mask. The select is one-shot. It returns to zero once the corruption has been emitted, so reading it back as zero confirms that the error went out. Selects that only make sense with three line-parity octets are honoured only when the mode input indicates STS-3c/STM-1. In STS-1 mode they stay pending and do nothing.

Top module: `ovh_err_inject`

## Requirements
- R1: The select picks the target byte: 001 section parity (role 1), 010 line-parity octet bits 23:16 (role 2), 011 octet bits 15:8 (role 3), 100 octet bits 7:0 (role 4), 101 path parity (role 5). The target byte leaves XORed with `err_pattern`. Selects 000 and 110 change nothing.
- R2: Select 111 XORs the same pattern into each of roles 2, 3 and 4. It stays armed until a role-4 byte has been corrupted.
- R3: Selects 010, 011 and 111 act only while `mode_sts3c`=1. Otherwise they stay pending and corrupt nothing. Selects 001, 100 and 101 act in both modes.
- R4: The select reads 000 on `err_sel_rd` in the same cycle as the corrupted byte appears on `out_data`. Later bytes of the same role pass unchanged.
- R5: With the force-zeros bit set, the bits of `FEBE_MASK` (default 8'hF0) in a role-6 byte leave as 0. The other bits of that byte are kept.
- R6: With the force-ones bit set, the `FEBE_MASK` bits of a role-6 byte leave as 1. Force-ones wins when both force bits are set.
- R7: Disable mask bits: bit0 section parity, bit1 all line-parity octets, bit2 path parity, bit3 FEBE byte, bit4 other overhead (role 7). A byte of a disabled field leaves as zero. Blanking wins over the FEBE force. A selected parity error is still XORed onto the blanked byte.
- R8: Payload bytes (role 0) are never altered. With the configuration all zero, every byte passes unchanged. `out_valid` repeats `in_valid` one cycle later, and `out_data` is 0 when `out_valid` is low.
- R9: A write on `cfg_we` applies to bytes presented from the next cycle on. A write in the cycle of a clearing hit overrides the clear.
- R10: Reset (synchronous, active high) clears the outputs, the select and all configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sts3c | input | 1 | 1: STS-3c/STM-1 framing, 0: STS-1 |
| err_pattern | input | DATA_W | XOR pattern applied to the selected parity byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_err_sel | input | 3 | Error select value to write |
| cfg_febe_zero | input | 1 | Force FEBE bits to zeros |
| cfg_febe_ones | input | 1 | Force FEBE bits to ones |
| cfg_dis_mask | input | 5 | Per-field overhead disable mask |
| in_valid | input | 1 | Input byte valid |
| in_role | input | 3 | Role tag of the input byte |
| in_data | input | DATA_W | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | DATA_W | Modified byte |
| err_sel_rd | output | 3 | Current error select, readable by software |

## Verification
A wrong select register shows up in two ways. A select that clears too early, or clears on an invalid mode, shows on `err_sel_rd` in the very cycle of the offending byte. A select that never clears corrupts the next matching byte one frame later. A faulty mode qualification or octet decode shows as a wrong `out_data` value one cycle after the affected role byte. A stale configuration register shows one cycle after the first byte that follows the write. The reference model compares all three outputs on every clock, so each fault is reported within one frame.

// File: rtl/ovh_inj_pkg.sv
package ovh_inj_pkg;

    typedef enum logic [2:0] {
        ROLE_PAY    = 3'd0,
        ROLE_B1     = 3'd1,
        ROLE_B2_HI  = 3'd2,
        ROLE_B2_MID = 3'd3,
        ROLE_B2_LO  = 3'd4,
        ROLE_B3     = 3'd5,
        ROLE_FEBE   = 3'd6,
        ROLE_OTH    = 3'd7
    } ovh_role_e;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_B1     = 3'd1,
        SEL_B2_HI  = 3'd2,
        SEL_B2_MID = 3'd3,
        SEL_B2_LO  = 3'd4,
        SEL_B3     = 3'd5,
        SEL_RSVD   = 3'd6,
        SEL_B2_ALL = 3'd7
    } err_sel_e;

    localparam int DIS_W    = 5;
    localparam int DIS_B1   = 0;
    localparam int DIS_B2   = 1;
    localparam int DIS_B3   = 2;
    localparam int DIS_FEBE = 3;
    localparam int DIS_OTH  = 4;

    typedef struct packed {
        logic             febe_zero;
        logic             febe_ones;
        logic [DIS_W-1:0] dis;
    } ovh_cfg_t;

    // Selects that address the upper line-parity octets need three octets.
    function automatic logic sel_allowed(err_sel_e s, logic sts3c);
        case (s)
            SEL_B1, SEL_B2_LO, SEL_B3:          return 1'b1;
            SEL_B2_HI, SEL_B2_MID, SEL_B2_ALL:  return sts3c;
            default:                            return 1'b0;
        endcase
    endfunction

    function automatic logic sel_targets(err_sel_e s, ovh_role_e r);
        case (s)
            SEL_B1:     return r == ROLE_B1;
            SEL_B2_HI:  return r == ROLE_B2_HI;
            SEL_B2_MID: return r == ROLE_B2_MID;
            SEL_B2_LO:  return r == ROLE_B2_LO;
            SEL_B3:     return r == ROLE_B3;
            SEL_B2_ALL: return r inside {ROLE_B2_HI, ROLE_B2_MID, ROLE_B2_LO};
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic role_blanked(ovh_role_e r, logic [DIS_W-1:0] dis);
        case (r)
            ROLE_B1:                              return dis[DIS_B1];
            ROLE_B2_HI, ROLE_B2_MID, ROLE_B2_LO:  return dis[DIS_B2];
            ROLE_B3:                              return dis[DIS_B3];
            ROLE_FEBE:                            return dis[DIS_FEBE];
            ROLE_OTH:                             return dis[DIS_OTH];
            default:                              return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ovh_err_sel.sv
module ovh_err_sel
    import ovh_inj_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  err_sel_e  wr_sel,
    input  logic      sts3c,
    input  logic      byte_valid,
    input  ovh_role_e byte_role,
    output logic      hit,
    output err_sel_e  sel_q
);
    logic last_target;

    always_comb begin
        hit         = byte_valid && sel_allowed(sel_q, sts3c) && sel_targets(sel_q, byte_role);
        last_target = (sel_q != SEL_B2_ALL) || (byte_role == ROLE_B2_LO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SEL_NONE;
        end else if (wr) begin
            sel_q <= wr_sel;
        end else if (hit && last_target) begin
            sel_q <= SEL_NONE;
        end
    end
endmodule

// File: rtl/ovh_byte_mod.sv
module ovh_byte_mod
    import ovh_inj_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] FEBE_MASK = 8'hF0
) (
    input  ovh_role_e         role,
    input  logic [DATA_W-1:0] din,
    input  ovh_cfg_t          cfg,
    input  logic              hit,
    input  logic [DATA_W-1:0] pattern,
    output logic [DATA_W-1:0] dout
);
    logic              blank;
    logic [DATA_W-1:0] stage;

    always_comb begin
        blank = role_blanked(role, cfg.dis);
        stage = blank ? '0 : din;
        if (role == ROLE_FEBE && !blank) begin
            if (cfg.febe_ones) begin
                stage = stage | FEBE_MASK;
            end else if (cfg.febe_zero) begin
                stage = stage & ~FEBE_MASK;
            end
        end
        dout = hit ? (stage ^ pattern) : stage;
    end
endmodule

// File: rtl/ovh_err_inject.sv
module ovh_err_inject
    import ovh_inj_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] FEBE_MASK = 8'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sts3c,
    input  logic [DATA_W-1:0] err_pattern,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_err_sel,
    input  logic              cfg_febe_zero,
    input  logic              cfg_febe_ones,
    input  logic [4:0]        cfg_dis_mask,
    input  logic              in_valid,
    input  logic [2:0]        in_role,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [2:0]        err_sel_rd
);
    ovh_cfg_t          cfg_q;
    ovh_role_e         role;
    err_sel_e          sel_q;
    logic              hit;
    logic [DATA_W-1:0] mod_byte;

    assign role       = ovh_role_e'(in_role);
    assign err_sel_rd = sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.febe_zero <= cfg_febe_zero;
            cfg_q.febe_ones <= cfg_febe_ones;
            cfg_q.dis       <= cfg_dis_mask;
        end
    end

    ovh_err_sel i_sel (
        .clk        (clk),
        .rst        (rst),
        .wr         (cfg_we),
        .wr_sel     (err_sel_e'(cfg_err_sel)),
        .sts3c      (mode_sts3c),
        .byte_valid (in_valid),
        .byte_role  (role),
        .hit        (hit),
        .sel_q      (sel_q)
    );

    ovh_byte_mod #(.DATA_W(DATA_W), .FEBE_MASK(FEBE_MASK)) i_mod (
        .role    (role),
        .din     (in_data),
        .cfg     (cfg_q),
        .hit     (hit),
        .pattern (err_pattern),
        .dout    (mod_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= in_valid ? mod_byte : '0;
        end
    end
endmodule

// File: rtl/ovh_err_inject_chk.sv
module ovh_err_inject_chk
    import ovh_inj_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] FEBE_MASK = 8'hF0
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_sts3c,
    input logic              cfg_we,
    input logic              in_valid,
    input logic [2:0]        in_role,
    input logic [DATA_W-1:0] in_data,
    input logic [DATA_W-1:0] out_data,
    input logic [2:0]        err_sel_rd,
    input logic              febe_ones_q,
    input logic              dis_febe_q,
    input logic              dis_oth_q
);
    AST_B1_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_role == ROLE_B1 && err_sel_rd == SEL_B1 && !cfg_we)
        |=> (err_sel_rd == SEL_NONE)); // R4

    AST_B2_ALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_role == ROLE_B2_HI && err_sel_rd == SEL_B2_ALL && !cfg_we)
        |=> (err_sel_rd == SEL_B2_ALL)); // R2

    AST_STS1_PENDING: assert property (@(posedge clk) disable iff (rst)
        (!mode_sts3c && err_sel_rd == SEL_B2_HI && !cfg_we)
        |=> (err_sel_rd == SEL_B2_HI)); // R3

    AST_FEBE_ONES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_role == ROLE_FEBE && febe_ones_q && !dis_febe_q)
        |=> ((out_data & FEBE_MASK) == FEBE_MASK)); // R6

    AST_OTH_BLANK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_role == ROLE_OTH && dis_oth_q)
        |=> (out_data == '0)); // R7

    AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_role == ROLE_PAY)
        |=> (out_data == $past(in_data))); // R8
endmodule

bind ovh_err_inject ovh_err_inject_chk #(.DATA_W(DATA_W), .FEBE_MASK(FEBE_MASK)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_sts3c  (mode_sts3c),
    .cfg_we      (cfg_we),
    .in_valid    (in_valid),
    .in_role     (in_role),
    .in_data     (in_data),
    .out_data    (out_data),
    .err_sel_rd  (err_sel_rd),
    .febe_ones_q (cfg_q.febe_ones),
    .dis_febe_q  (cfg_q.dis[3]),
    .dis_oth_q   (cfg_q.dis[4])
);

// File: tb/test_ovh_err_inject.sv
`timescale 1ns/1ps
module test_ovh_err_inject;
    logic       clk = 0;
    logic       rst = 1;
    logic       mode_sts3c = 1;
    logic [7:0] err_pattern = 8'h5A;
    logic       cfg_we = 0;
    logic [2:0] cfg_err_sel = 0;
    logic       cfg_febe_zero = 0;
    logic       cfg_febe_ones = 0;
    logic [4:0] cfg_dis_mask = 0;
    logic       in_valid = 0;
    logic [2:0] in_role = 0;
    logic [7:0] in_data = 0;
    logic       out_valid;
    logic [7:0] out_data;
    logic [2:0] err_sel_rd;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R10";

    // reference model state
    int   m_sel = 0;
    bit   m_fz = 0, m_fo = 0;
    int   m_dis = 0;
    bit   e_valid = 0;
    int   e_data = 0;

    always #2.5 clk = ~clk;

    ovh_err_inject i_ovh_err_inject (
        .clk(clk), .rst(rst), .mode_sts3c(mode_sts3c), .err_pattern(err_pattern),
        .cfg_we(cfg_we), .cfg_err_sel(cfg_err_sel), .cfg_febe_zero(cfg_febe_zero),
        .cfg_febe_ones(cfg_febe_ones), .cfg_dis_mask(cfg_dis_mask),
        .in_valid(in_valid), .in_role(in_role), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .err_sel_rd(err_sel_rd)
    );

    function automatic bit model_hit(int sel, int role, bit sts3c);
        case (sel)
            1: return role == 1;
            2: return sts3c && role == 2;
            3: return sts3c && role == 3;
            4: return role == 4;
            5: return role == 5;
            7: return sts3c && (role >= 2 && role <= 4);
            default: return 0;
        endcase
    endfunction

    function automatic bit model_blank(int role, int dis);
        if (role == 1) return dis[0];
        if (role >= 2 && role <= 4) return dis[1];
        if (role == 5) return dis[2];
        if (role == 6) return dis[3];
        if (role == 7) return dis[4];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sel = 0; m_fz = 0; m_fo = 0; m_dis = 0; e_valid = 0; e_data = 0;
        end else begin
            bit h;
            int b;
            h = in_valid && model_hit(m_sel, in_role, mode_sts3c);
            b = in_data;
            if (model_blank(in_role, m_dis)) b = 0;
            else if (in_role == 6) begin
                if (m_fo) b = b | 8'hF0;
                else if (m_fz) b = b & 8'h0F;
            end
            if (h) b = b ^ err_pattern;
            e_valid = in_valid;
            e_data  = in_valid ? b : 0;
            if (cfg_we) begin
                m_sel = cfg_err_sel; m_fz = cfg_febe_zero; m_fo = cfg_febe_ones; m_dis = cfg_dis_mask;
            end else if (h && (m_sel != 7 || in_role == 4)) begin
                m_sel = 0;
            end
        end
    end

    task automatic compare();
        n_tests++;
        if (out_valid !== e_valid || out_data !== e_data[7:0] || err_sel_rd !== m_sel[2:0]) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b data=%02h sel=%0d, expected valid=%0b data=%02h sel=%0d",
                     cur_req, out_valid, out_data, err_sel_rd, e_valid, e_data[7:0], m_sel);
        end
    endtask

    task automatic cyc(input bit v, input int r, input int d, input bit we);
        @(negedge clk);
        compare();
        in_valid = v; in_role = r[2:0]; in_data = d[7:0]; cfg_we = we;
    endtask

    task automatic wr(input int sel, input bit fz, input bit fo, input int dis);
        cfg_err_sel = sel[2:0]; cfg_febe_zero = fz; cfg_febe_ones = fo; cfg_dis_mask = dis[4:0];
        cyc(0, 0, 0, 1);
    endtask

    task automatic frame(input int base);
        for (int r = 1; r <= 7; r++) cyc(1, r, base + r * 17, 0);
        cyc(1, 0, base + 3, 0);
        cyc(0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cur_req = "R10";
        repeat (3) cyc(0, 0, 0, 0);
        rst = 0;
        cyc(0, 0, 0, 0);
        cur_req = "R8";  frame(8'h10); cyc(1, 0, 8'hFF, 0); cyc(0, 0, 0, 0);
        cur_req = "R1";
        for (int s = 1; s <= 6; s++) begin wr(s, 0, 0, 0); frame(8'h20 + s); end
        cur_req = "R4";  wr(1, 0, 0, 0); frame(8'h31); frame(8'h32);
        cur_req = "R2";  wr(7, 0, 0, 0); frame(8'h41); frame(8'h42);
        cur_req = "R3";  mode_sts3c = 0; wr(2, 0, 0, 0); frame(8'h51); frame(8'h52);
        mode_sts3c = 1; frame(8'h53);
        mode_sts3c = 0; wr(7, 0, 0, 0); frame(8'h54); wr(4, 0, 0, 0); frame(8'h55);
        wr(5, 0, 0, 0); frame(8'h56); mode_sts3c = 1;
        cur_req = "R5";  wr(0, 1, 0, 0); frame(8'h67);
        cur_req = "R6";  wr(0, 0, 1, 0); frame(8'h68); wr(0, 1, 1, 0); frame(8'h69);
        cur_req = "R7";
        for (int k = 0; k < 5; k++) begin wr(0, 0, 1, 1 << k); frame(8'h70 + k); end
        wr(1, 0, 1, 5'h1F); frame(8'h7A);
        err_pattern = 8'hC3;
        cur_req = "R9";
        wr(0, 0, 0, 0);
        cfg_err_sel = 5; cyc(1, 5, 8'h99, 1); cyc(1, 5, 8'h98, 0); cyc(0, 0, 0, 0);
        wr(1, 0, 0, 0);
        cfg_err_sel = 5; cyc(1, 1, 8'h97, 1); cyc(1, 5, 8'h96, 0); cyc(0, 0, 0, 0);
        cfg_err_sel = 0; cfg_dis_mask = 5'h10; cyc(1, 7, 8'h95, 1); cyc(1, 7, 8'h94, 0);
        cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        cur_req = "R10"; rst = 1; cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); rst = 0; cyc(0, 0, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule